// File: doc/BRIEF.md
# Processor-to-ISA I/O Window Bridge

This block sits between a processor-side request port and a downstream I/O port bus. A processor access whose 32-bit address lands inside a fixed 8 MB window (base 0x8000_0000) is turned into an I/O port access. The window offset is folded into a port number in one of two ways. In the flat map, the port is the low 16 offset bits. In the scattered map, each 4 KB page of the window covers one group of 32 ports. Accesses outside the window, or with a reserved size code, are answered with an error and never reach the downstream bus.

Data can be byte-reversed for a big-endian processor. Halfword accesses exchange their two bytes and word accesses reverse all four bytes, in both the write and the read direction. Byte accesses pass through unchanged. The bridge handles one transaction at a time. It latches the request on acceptance, presents it downstream, waits for the response and then returns one response beat upstream.

Top module: `isa_io_bridge`

## Requirements
- R1: During and directly after reset, `up_ready` is 1 and `dn_valid` and `up_rsp_valid` are 0.
- R2: With `map_sel`=0 when the request is accepted, an in-window access drives `dn_addr` with window offset bits 15..0, zero-extended to 20 bits.
- R3: With `map_sel`=1 when the request is accepted, `dn_addr` holds offset bits 22..12 in bits 15..5 and offset bits 4..0 in bits 4..0, and bits 19..16 are zero.
- R4: A request whose address bits 31..23 differ from 9'h100 issues no downstream request. In the cycle after acceptance it is answered with `up_rsp_valid`=1, `up_err`=1 and `up_rdata`=32'hFFFF_FFFF.
- R5: Size code 3 is reserved and is rejected exactly as R4 describes, even for an in-window address. The other size codes are 0 for byte, 1 for halfword and 2 for word. `dn_size` and `dn_write` repeat the accepted size and write flag.
- R6: With `big_endian`=1, write data are sent downstream with bytes [7:0],[15:8] exchanged for halfwords and with byte order 3,2,1,0 reversed for words.
- R7: With `big_endian`=1, read data from `dn_rdata` are returned on `up_rdata` with the same swap as R6, chosen by the size of the access.
- R8: Byte accesses are never swapped, and with `big_endian`=0 no access is swapped. In every case, data bits above the access width are driven 0 in both directions.
- R9: Only one transaction is in flight. `up_ready` goes low in the cycle after acceptance and returns high only in the cycle after the response beat.
- R10: `map_sel` and `big_endian` are sampled at acceptance. A change while the access is in flight does not alter `dn_addr` or the data handling of that access.
- R11: While `dn_valid`=1 and `dn_ready`=0, `dn_valid` stays high and `dn_addr`, `dn_size`, `dn_write` and `dn_wdata` stay stable.
- R12: `up_rsp_valid` is a single-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| map_sel | input | 1 | Address map: 0 flat, 1 scattered pages |
| big_endian | input | 1 | Enables byte swapping of halfword and word data |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Bridge can accept a request |
| up_addr | input | 32 | Processor physical address |
| up_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| up_write | input | 1 | 1 write, 0 read |
| up_wdata | input | 32 | Write data, right-justified |
| up_rsp_valid | output | 1 | Upstream response beat |
| up_rdata | output | 32 | Read data, or all-ones on error |
| up_err | output | 1 | Access was rejected |
| dn_valid | output | 1 | Downstream port request valid |
| dn_ready | input | 1 | Downstream accepts the request |
| dn_addr | output | 20 | I/O port number |
| dn_size | output | 2 | Access size code |
| dn_write | output | 1 | Downstream write flag |
| dn_wdata | output | 32 | Downstream write data after swap and mask |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rdata | input | 32 | Downstream read data |

## Verification
The hardest situation to reach is a change of `map_sel` while an access is already in flight. This change must be ignored. The bench accepts a request and then flips `map_sel` on the very next falling edge, before the downstream request is examined. It then compares `dn_addr` against the map that was in force at acceptance. Holding the downstream request also needs deliberate stimulus: the bench withholds `dn_ready` for several cycles on a rotating subset of the sweep and checks that every request field stays unchanged.

// File: rtl/isa_bridge_pkg.sv
// Shared types for the I/O window bridge.
package isa_bridge_pkg;
    // Access size code carried on the upstream and downstream ports.
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    // Transaction sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_RESP = 2'd3
    } xfer_state_e;
endpackage

// File: rtl/io_window_map.sv
// Window decoder and port-number former.
// Flags whether an address falls in the power-of-two window at WIN_BASE.
// Forms the port number either flat (low FLAT_W offset bits) or scattered:
// the page index lands above the in-group bits.
// Assumes WIN_BASE is aligned to 2**WIN_LOG2 and that the scattered
// port fits in PORT_W bits.
module io_window_map #(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE   = 32'h8000_0000,
    parameter int                WIN_LOG2   = 23,
    parameter int                PAGE_LOG2  = 12,
    parameter int                GROUP_LOG2 = 5,
    parameter int                FLAT_W     = 16,
    parameter int                PORT_W     = 20
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              map_sel,
    output logic              hit,
    output logic [PORT_W-1:0] port
);
    localparam int PAGE_W = WIN_LOG2 - PAGE_LOG2;
    localparam int SCAT_W = PAGE_W + GROUP_LOG2;

    logic [WIN_LOG2-1:0] offset;
    logic [PORT_W-1:0]   flat_port;
    logic [PORT_W-1:0]   scat_port;
    logic [SCAT_W-1:0]   scat_raw;

    // Window hit on the upper address bits; the offset is what remains.
    always_comb begin
        hit    = (addr[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]);
        offset = addr[WIN_LOG2-1:0];
    end

    // Both candidate port numbers; the map select picks one.
    always_comb begin
        flat_port = PORT_W'(offset[FLAT_W-1:0]);
        scat_raw  = {offset[WIN_LOG2-1:PAGE_LOG2], offset[GROUP_LOG2-1:0]};
        scat_port = PORT_W'(scat_raw);
        port      = map_sel ? scat_port : flat_port;
    end
endmodule

// File: rtl/lane_swap.sv
// Byte-lane swapper and masker.
// For the given access size it keeps only the lanes that belong to the
// access. When swap_en is set it reverses their order. Lanes above the
// access width are zeroed. Assumes DATA_W is a multiple of 8 and at least 32.
module lane_swap
    import isa_bridge_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  size_e             size,
    input  logic              swap_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int LANES = DATA_W / 8;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam bit IN_HALF = (i < 2);
        localparam bit IN_WORD = (i < 4);
        localparam int HSRC    = IN_HALF ? (1 - i) : i;
        localparam int WSRC    = IN_WORD ? (3 - i) : i;
        logic [7:0] lane;

        // Pick the source byte of this lane for the current size.
        always_comb begin
            lane = 8'h00;
            case (size)
                SZ_BYTE: if (i == 0) lane = din[7:0];
                SZ_HALF: if (IN_HALF) lane = swap_en ? din[8*HSRC +: 8] : din[8*i +: 8];
                SZ_WORD: if (IN_WORD) lane = swap_en ? din[8*WSRC +: 8] : din[8*i +: 8];
                default: lane = 8'h00;
            endcase
        end

        assign dout[8*i +: 8] = lane;
    end
endmodule

// File: rtl/xfer_ctrl.sv
// Single-transaction sequencer.
// Accepts one upstream request while idle and latches its already-mapped
// port and already-swapped write data. A legal request goes downstream and
// waits for the response. A rejected one is answered directly with an error.
// Assumes the downstream answers each accepted request with one response.
module xfer_ctrl
    import isa_bridge_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PORT_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic              acc_ok,
    input  logic [PORT_W-1:0] acc_port,
    input  size_e             acc_size,
    input  logic              acc_write,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              acc_be,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [PORT_W-1:0] dn_addr,
    output size_e             dn_size,
    output logic              dn_write,
    output logic [DATA_W-1:0] dn_wdata,
    input  logic              dn_rsp_valid,
    input  logic [DATA_W-1:0] rd_swapped,
    output logic              cur_be,
    output logic              up_rsp_valid,
    output logic [DATA_W-1:0] up_rdata,
    output logic              up_err
);
    xfer_state_e       state;
    logic              err_q;
    logic [DATA_W-1:0] rdata_q;

    // State sequencing and capture of the request and the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            err_q    <= 1'b0;
            rdata_q  <= '0;
            dn_addr  <= '0;
            dn_size  <= SZ_BYTE;
            dn_write <= 1'b0;
            dn_wdata <= '0;
            cur_be   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (up_valid) begin
                        dn_addr  <= acc_port;
                        dn_size  <= acc_size;
                        dn_write <= acc_write;
                        dn_wdata <= acc_wdata;
                        cur_be   <= acc_be;
                        if (acc_ok) begin
                            err_q <= 1'b0;
                            state <= ST_REQ;
                        end else begin
                            err_q   <= 1'b1;
                            rdata_q <= '1;
                            state   <= ST_RESP;
                        end
                    end
                end
                ST_REQ:  if (dn_ready) state <= ST_WAIT;
                ST_WAIT: begin
                    if (dn_rsp_valid) begin
                        rdata_q <= rd_swapped;
                        state   <= ST_RESP;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Handshake outputs decoded from the state.
    always_comb begin
        up_ready     = (state == ST_IDLE);
        dn_valid     = (state == ST_REQ);
        up_rsp_valid = (state == ST_RESP);
        up_err       = (state == ST_RESP) && err_q;
        up_rdata     = rdata_q;
    end
endmodule

// File: rtl/isa_io_bridge.sv
// Processor-to-I/O-port window bridge, top level.
// Maps upstream addresses in the I/O window onto port numbers and swaps
// data for a big-endian processor. Carries one access at a time to the
// downstream port bus. Assumes upstream data are right-justified.
module isa_io_bridge
    import isa_bridge_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                DATA_W     = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE   = 32'h8000_0000,
    parameter int                WIN_LOG2   = 23,
    parameter int                PAGE_LOG2  = 12,
    parameter int                GROUP_LOG2 = 5,
    parameter int                FLAT_W     = 16,
    parameter int                PORT_W     = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_sel,
    input  logic              big_endian,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [1:0]        up_size,
    input  logic              up_write,
    input  logic [DATA_W-1:0] up_wdata,
    output logic              up_rsp_valid,
    output logic [DATA_W-1:0] up_rdata,
    output logic              up_err,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [PORT_W-1:0] dn_addr,
    output logic [1:0]        dn_size,
    output logic              dn_write,
    output logic [DATA_W-1:0] dn_wdata,
    input  logic              dn_rsp_valid,
    input  logic [DATA_W-1:0] dn_rdata
);
    logic              win_hit;
    logic              acc_ok;
    logic [PORT_W-1:0] acc_port;
    logic [DATA_W-1:0] acc_wdata;
    logic [DATA_W-1:0] rd_swapped;
    logic              cur_be;
    size_e             req_size;
    size_e             dn_size_e;

    // Legal requests hit the window and use a defined size code.
    always_comb begin
        req_size = size_e'(up_size);
        acc_ok   = win_hit && (req_size != SZ_RSVD);
        dn_size  = dn_size_e;
    end

    io_window_map #(
        .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2),
        .PAGE_LOG2(PAGE_LOG2), .GROUP_LOG2(GROUP_LOG2),
        .FLAT_W(FLAT_W), .PORT_W(PORT_W)
    ) u_map (
        .addr(up_addr), .map_sel(map_sel), .hit(win_hit), .port(acc_port)
    );

    lane_swap #(.DATA_W(DATA_W)) u_wr_swap (
        .size(req_size), .swap_en(big_endian), .din(up_wdata), .dout(acc_wdata)
    );

    lane_swap #(.DATA_W(DATA_W)) u_rd_swap (
        .size(dn_size_e), .swap_en(cur_be), .din(dn_rdata), .dout(rd_swapped)
    );

    xfer_ctrl #(.DATA_W(DATA_W), .PORT_W(PORT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .up_valid(up_valid), .up_ready(up_ready),
        .acc_ok(acc_ok), .acc_port(acc_port), .acc_size(req_size),
        .acc_write(up_write), .acc_wdata(acc_wdata), .acc_be(big_endian),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr),
        .dn_size(dn_size_e), .dn_write(dn_write), .dn_wdata(dn_wdata),
        .dn_rsp_valid(dn_rsp_valid), .rd_swapped(rd_swapped), .cur_be(cur_be),
        .up_rsp_valid(up_rsp_valid), .up_rdata(up_rdata), .up_err(up_err)
    );
endmodule

// File: rtl/isa_io_bridge_chk.sv
// Protocol checker for the I/O window bridge, attached by bind.
module isa_io_bridge_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int PORT_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              up_valid,
    input logic              up_ready,
    input logic [ADDR_W-1:0] up_addr,
    input logic [1:0]        up_size,
    input logic              up_rsp_valid,
    input logic [DATA_W-1:0] up_rdata,
    input logic              up_err,
    input logic              dn_valid,
    input logic              dn_ready,
    input logic [PORT_W-1:0] dn_addr,
    input logic [1:0]        dn_size,
    input logic              dn_write,
    input logic [DATA_W-1:0] dn_wdata
);
    logic reject_now;

    // Independent rejection decode from the raw request.
    always_comb reject_now = (up_addr[ADDR_W-1:23] != 9'h100) || (up_size == 2'd3);

    // R4, R5: a rejected request is answered next cycle with no downstream request.
    a_r4_reject_no_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready && reject_now) |=> (up_rsp_valid && up_err && !dn_valid));

    // R4: the error beat always carries all-ones data.
    a_r4_err_data: assert property (@(posedge clk) disable iff (!rst_n)
        up_err |-> (up_rsp_valid && (up_rdata == '1)));

    // R9: acceptance closes the upstream port.
    a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready) |=> !up_ready);

    // R9: no new acceptance while a downstream request is pending.
    a_r9_busy_downstream: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> !up_ready);

    // R11: a stalled downstream request holds all of its fields.
    a_r11_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) && $stable(dn_size)
                                     && $stable(dn_write) && $stable(dn_wdata)));

    // R12: the response beat lasts one cycle.
    a_r12_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
        up_rsp_valid |=> !up_rsp_valid);
endmodule

bind isa_io_bridge isa_io_bridge_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_W(PORT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
    .up_addr(up_addr), .up_size(up_size), .up_rsp_valid(up_rsp_valid),
    .up_rdata(up_rdata), .up_err(up_err), .dn_valid(dn_valid),
    .dn_ready(dn_ready), .dn_addr(dn_addr), .dn_size(dn_size),
    .dn_write(dn_write), .dn_wdata(dn_wdata)
);

// File: tb/isa_io_bridge_tb.sv
module isa_io_bridge_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_sel = 1'b0;
    logic        big_endian = 1'b0;
    logic        up_valid = 1'b0;
    logic        up_ready;
    logic [31:0] up_addr = '0;
    logic [1:0]  up_size = '0;
    logic        up_write = 1'b0;
    logic [31:0] up_wdata = '0;
    logic        up_rsp_valid;
    logic [31:0] up_rdata;
    logic        up_err;
    logic        dn_valid;
    logic        dn_ready = 1'b0;
    logic [19:0] dn_addr;
    logic [1:0]  dn_size;
    logic        dn_write;
    logic [31:0] dn_wdata;
    logic        dn_rsp_valid = 1'b0;
    logic [31:0] dn_rdata = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Results captured by the access task.
    logic        g_fwd, g_err;
    logic [19:0] g_addr;
    logic [1:0]  g_size;
    logic        g_write;
    logic [31:0] g_wdata, g_rdata;

    always #2 clk = ~clk;

    isa_io_bridge u_dut (.*);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_data(input logic [1:0] sz, input logic be, input logic [31:0] d);
        case (sz)
            2'd0:    return {24'h0, d[7:0]};
            2'd1:    return be ? {16'h0, d[7:0], d[15:8]} : {16'h0, d[15:0]};
            2'd2:    return be ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [19:0] exp_port(input logic ms, input logic [31:0] a);
        return ms ? {4'h0, a[22:12], a[4:0]} : {4'h0, a[15:0]};
    endfunction

    // One access; the downstream side is modelled here with an optional stall.
    task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                          input logic [31:0] wd, input logic [31:0] rd, input int stall,
                          input bit flip_mode);
        bit done = 0;
        bit seen = 0;
        int left = stall;
        g_fwd = 0; g_err = 0; g_addr = '0; g_size = '0; g_write = 0; g_wdata = '0; g_rdata = '0;
        @(negedge clk);
        chk(up_ready == 1'b1, "R9 ready before accept", {31'h0, up_ready}, 32'h1);
        up_valid = 1; up_addr = a; up_size = sz; up_write = wr; up_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        up_valid = 0;
        if (flip_mode) begin
            map_sel = ~map_sel;
            big_endian = ~big_endian;
        end
        chk(up_ready == 1'b0, "R9 ready low after accept", {31'h0, up_ready}, 32'h0);
        for (int n = 0; n < 60 && !done; n++) begin
            if (up_rsp_valid) begin
                g_err = up_err; g_rdata = up_rdata; done = 1;
            end else if (dn_valid) begin
                if (!seen) begin
                    seen = 1; g_fwd = 1; g_addr = dn_addr; g_size = dn_size;
                    g_write = dn_write; g_wdata = dn_wdata;
                end else begin
                    chk((dn_addr == g_addr) && (dn_wdata == g_wdata) && (dn_size == g_size)
                        && (dn_write == g_write), "R11 stalled request stable",
                        {12'h0, dn_addr}, {12'h0, g_addr});
                end
                if (left > 0) begin
                    left--;
                    @(posedge clk); @(negedge clk);
                end else begin
                    dn_ready = 1;
                    @(posedge clk); @(negedge clk);
                    dn_ready = 0;
                    chk(up_ready == 1'b0, "R9 busy while waiting", {31'h0, up_ready}, 32'h0);
                    dn_rsp_valid = 1; dn_rdata = rd;
                    @(posedge clk); @(negedge clk);
                    dn_rsp_valid = 0; dn_rdata = 32'hDEAD_BEEF;
                end
            end else begin
                @(posedge clk); @(negedge clk);
            end
        end
        chk(done, "R12 response arrived", {31'h0, done}, 32'h1);
        @(posedge clk); @(negedge clk);
        chk(up_rsp_valid == 1'b0, "R12 single beat", {31'h0, up_rsp_valid}, 32'h0);
        chk(up_ready == 1'b1, "R9 ready after response", {31'h0, up_ready}, 32'h1);
    endtask

    initial begin
        // R1: state during and after reset.
        repeat (3) @(negedge clk);
        chk(up_ready && !dn_valid && !up_rsp_valid, "R1 in reset",
            {29'h0, up_ready, dn_valid, up_rsp_valid}, 32'h4);
        rst_n = 1;
        @(negedge clk);
        chk(up_ready && !dn_valid && !up_rsp_valid, "R1 after reset",
            {29'h0, up_ready, dn_valid, up_rsp_valid}, 32'h4);

        // Sweep of modes, endianness, sizes, directions and offsets.
        for (int ms = 0; ms < 2; ms++) begin
            for (int be = 0; be < 2; be++) begin
                for (int sz = 0; sz < 3; sz++) begin
                    for (int wr = 0; wr < 2; wr++) begin
                        for (int k = 0; k < 10; k++) begin
                            logic [31:0] off, a, wd, rd;
                            string dtag;
                            off = (k == 8) ? 32'h0 : (k == 9) ? 32'h7F_FFFF
                                : ((k * 32'h0013_579B + 32'h35) & 32'h7F_FFFF);
                            a  = 32'h8000_0000 | off;
                            wd = 32'hA1B2_C3D4 ^ (k * 32'h0101_0101);
                            rd = 32'h5E6F_7A8B + k;
                            map_sel = ms[0]; big_endian = be[0];
                            access(a, sz[1:0], wr[0], wd, rd, k % 3, 0);
                            chk(g_fwd && !g_err, "R4 in-window forwarded", {30'h0, g_fwd, g_err}, 32'h2);
                            chk(g_addr == exp_port(ms[0], a), ms ? "R3 scattered port" : "R2 flat port",
                                {12'h0, g_addr}, {12'h0, exp_port(ms[0], a)});
                            chk(g_size == sz[1:0] && g_write == wr[0], "R5 size and write forwarded",
                                {29'h0, g_write, g_size}, {29'h0, wr[0], sz[1:0]});
                            if (sz == 0 || be == 0) dtag = "R8 no swap and mask";
                            else dtag = wr ? "R6 write swap" : "R7 read swap";
                            if (wr != 0)
                                chk(g_wdata == exp_data(sz[1:0], be[0], wd), dtag, g_wdata,
                                    exp_data(sz[1:0], be[0], wd));
                            else
                                chk(g_rdata == exp_data(sz[1:0], be[0], rd), dtag, g_rdata,
                                    exp_data(sz[1:0], be[0], rd));
                        end
                    end
                end
            end
        end

        // R4: addresses just outside and far from the window.
        for (int k = 0; k < 5; k++) begin
            logic [31:0] a;
            case (k)
                0: a = 32'h7FFF_FFFF;
                1: a = 32'h8080_0000;
                2: a = 32'h0000_0000;
                3: a = 32'hFFFF_FFFF;
                default: a = 32'h0080_0000;
            endcase
            access(a, 2'd2, k[0], 32'h1234_5678, 32'h0, 0, 0);
            chk(!g_fwd, "R4 no downstream request", {31'h0, g_fwd}, 32'h0);
            chk(g_err && g_rdata == 32'hFFFF_FFFF, "R4 error and all-ones", g_rdata, 32'hFFFF_FFFF);
        end

        // R5: reserved size code inside the window.
        access(32'h8000_0100, 2'd3, 1'b0, 32'h0, 32'h0, 0, 0);
        chk(!g_fwd && g_err, "R5 reserved size rejected", {30'h0, g_fwd, g_err}, 32'h1);
        chk(g_rdata == 32'hFFFF_FFFF, "R5 reserved size data", g_rdata, 32'hFFFF_FFFF);

        // R10: flipping map and endian settings right after acceptance.
        map_sel = 0; big_endian = 1;
        access(32'h8012_3456, 2'd2, 1'b0, 32'h0, 32'h1122_3344, 2, 1);
        chk(g_addr == exp_port(1'b0, 32'h8012_3456), "R10 map sampled at accept",
            {12'h0, g_addr}, {12'h0, exp_port(1'b0, 32'h8012_3456)});
        chk(g_rdata == 32'h4433_2211, "R10 endian sampled at accept", g_rdata, 32'h4433_2211);
        map_sel = 1; big_endian = 0;
        access(32'h8054_3217, 2'd1, 1'b1, 32'h0000_ABCD, 32'h0, 1, 1);
        chk(g_addr == exp_port(1'b1, 32'h8054_3217), "R10 map sampled at accept",
            {12'h0, g_addr}, {12'h0, exp_port(1'b1, 32'h8054_3217)});
        chk(g_wdata == 32'h0000_ABCD, "R10 endian sampled at accept", g_wdata, 32'h0000_ABCD);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule